// File: doc/BRIEF.md
# Fixed-Point Multiply-Accumulate Datapath

This block is the arithmetic core of a 16-bit fixed-point signal processor. Each clock it performs one operation chosen by a 4-bit opcode. The operation uses a 16-bit operand taken either from the data bus or from an immediate field. The block holds a 16-bit multiplicand register, a 32-bit product register, a 32-bit accumulator and a 32-bit accumulator buffer.

Three shifters scale values as they move. On the way into the ALU, operands are sign-extended and shifted left by 0 to 16 bits. The product is scaled by one of four fixed modes before the ALU uses it. Accumulator halves pass through a 0 to 7 bit left shifter on their way to the store bus. A multiply-accumulate adds the previous, scaled product to the accumulator and captures a new product in the same cycle, which lets a filter loop issue one tap per clock. Instruction decode, memories and sequencing belong to the surrounding core.

Top module: `fxp_mac_core`

## Requirements
- R1: A synchronous reset (`rst_n` low at a clock edge) clears the accumulator, accumulator buffer, multiplicand register, product register and overflow flag to zero.
- R2: Opcode 1 (load multiplicand) writes the selected 16-bit operand into the multiplicand register. The operand is `imm_i` when `src_imm_i` is 1 and `bus_i` when it is 0.
- R3: Opcode 2 (multiply) writes the 32-bit two's complement product of the multiplicand register and the operand into the product register in one cycle.
- R4: Wherever the product feeds the ALU, it is first scaled by `pmode_i`: 0 leaves it unshifted, 1 shifts it left by 1, 2 shifts it left by 4, and 3 shifts it right by 6 with sign extension. Opcodes 7 (add product), 8 (subtract product) and 9 (load product) use this scaled value.
- R5: For opcodes 4 (load), 5 (add), 6 (subtract), 10, 11 and 12, the operand is sign-extended to 32 bits and shifted left by `ish_i`. Shift values above 16 behave as 16.
- R6: Accumulator arithmetic wraps modulo 2^32. Opcodes 3, 5, 6, 7, 8, 14 and 15 set `ovf_o` to 1 on signed overflow and to 0 otherwise. Opcodes 4, 9, 10, 11 and 12 clear `ovf_o`. All other opcodes leave it unchanged.
- R7: Opcodes 10, 11 and 12 replace the accumulator with its bitwise AND, OR or XOR, respectively, with the scaled operand.
- R8: Opcode 13 copies the accumulator into the buffer. Opcode 14 adds the buffer to the accumulator and opcode 15 subtracts it.
- R9: Opcode 3 (multiply-accumulate) adds the scaled old product to the accumulator and, in the same cycle, loads the product register with the multiplicand times the operand.
- R10: `store_o` is the combinational value of the accumulator shifted left by `osh_i` (0 to 7) within 32 bits. It gives bits 31:16 of that value when `ohi_i` is 1 and bits 15:0 when it is 0.
- R11: Opcode 0 leaves every register and the overflow flag unchanged, whatever the operand inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_i | input | 4 | Operation code |
| src_imm_i | input | 1 | 1 selects immediate operand, 0 selects bus |
| bus_i | input | 16 | Data bus operand |
| imm_i | input | 16 | Immediate operand |
| ish_i | input | 5 | Input scaling left shift (0..16, larger clamps) |
| pmode_i | input | 2 | Product scaling mode |
| osh_i | input | 3 | Store output left shift |
| ohi_i | input | 1 | Store high half when 1, low half when 0 |
| acc_o | output | 32 | Accumulator |
| accb_o | output | 32 | Accumulator buffer |
| treg_o | output | 16 | Multiplicand register |
| preg_o | output | 32 | Product register |
| store_o | output | 16 | Shifted accumulator half for storing |
| ovf_o | output | 1 | Signed overflow of last accumulating operation |

## Verification
The bench targets the ordering inside a multiply-accumulate. A design that added the new product, instead of the old one, would show an accumulator off by exactly one product term. The right-by-6 mode is tested on a negative product: a logical shift would leave a large positive number where the bench expects a small negative one. Scaling shifts of 16 and above must put the operand in the high word. A design that wrapped the shift amount would load a small value instead. Overflow is driven in both directions, through add, subtract and the buffer operations, and the store shifter is checked at shifts 4 and 7. A half-only shifter would lose the low-word bits that ought to rise into the stored high word.

// File: rtl/mac_pkg.sv
package mac_pkg;

    typedef enum logic [3:0] {
        OP_NOP  = 4'd0,
        OP_LDT  = 4'd1,
        OP_MPY  = 4'd2,
        OP_MAC  = 4'd3,
        OP_LAC  = 4'd4,
        OP_ADD  = 4'd5,
        OP_SUB  = 4'd6,
        OP_APAC = 4'd7,
        OP_SPAC = 4'd8,
        OP_PAC  = 4'd9,
        OP_AND  = 4'd10,
        OP_OR   = 4'd11,
        OP_XOR  = 4'd12,
        OP_SACB = 4'd13,
        OP_ADDB = 4'd14,
        OP_SUBB = 4'd15
    } mac_op_e;

    typedef enum logic [1:0] {
        PM_NONE = 2'd0,
        PM_L1   = 2'd1,
        PM_L4   = 2'd2,
        PM_R6   = 2'd3
    } pmode_e;

endpackage

// File: rtl/mac_in_scaler.sv
module mac_in_scaler #(
    parameter int DW     = 16,
    parameter int AW     = 32,
    parameter int MAX_SH = 16,
    parameter int SHW    = 5
) (
    input  logic [DW-1:0]  data_i,
    input  logic [SHW-1:0] sh_i,
    output logic [AW-1:0]  data_o
);
    logic [AW-1:0]  ext_w;
    logic [SHW-1:0] amt_w;

    always_comb begin
        ext_w  = {{(AW-DW){data_i[DW-1]}}, data_i};
        amt_w  = (sh_i > SHW'(MAX_SH)) ? SHW'(MAX_SH) : sh_i;
        data_o = ext_w << amt_w;
    end
endmodule

// File: rtl/mac_prod_scaler.sv
module mac_prod_scaler
    import mac_pkg::*;
#(
    parameter int AW   = 32,
    parameter int SH_A = 1,
    parameter int SH_B = 4,
    parameter int SH_R = 6
) (
    input  logic [AW-1:0] prod_i,
    input  logic [1:0]    mode_i,
    output logic [AW-1:0] prod_o
);
    pmode_e mode_w;

    always_comb begin
        mode_w = pmode_e'(mode_i);
        unique case (mode_w)
            PM_NONE: prod_o = prod_i;
            PM_L1:   prod_o = prod_i << SH_A;
            PM_L4:   prod_o = prod_i << SH_B;
            PM_R6:   prod_o = AW'($signed(prod_i) >>> SH_R);
            default: prod_o = prod_i;
        endcase
    end
endmodule

// File: rtl/mac_out_shifter.sv
module mac_out_shifter #(
    parameter int DW  = 16,
    parameter int AW  = 32,
    parameter int OSW = 3
) (
    input  logic [AW-1:0]  acc_i,
    input  logic [OSW-1:0] sh_i,
    input  logic           hi_i,
    output logic [DW-1:0]  store_o
);
    logic [AW-1:0] shifted_w;

    always_comb begin
        shifted_w = acc_i << sh_i;
        store_o   = hi_i ? shifted_w[AW-1:AW-DW] : shifted_w[DW-1:0];
        if (sh_i == '0) begin
            p_out_noshift_r10: assert (store_o == (hi_i ? acc_i[AW-1:AW-DW] : acc_i[DW-1:0]));
        end
    end
endmodule

// File: rtl/mac_alu.sv
module mac_alu
    import mac_pkg::*;
#(
    parameter int AW = 32
) (
    input  mac_op_e       op_i,
    input  logic [AW-1:0] acc_i,
    input  logic [AW-1:0] opnd_i,
    input  logic [AW-1:0] prod_i,
    input  logic [AW-1:0] accb_i,
    output logic [AW-1:0] acc_o,
    output logic          acc_we_o,
    output logic          ovf_o,
    output logic          ovf_we_o
);
    logic [AW-1:0] y_w;
    logic [AW-1:0] sum_w;
    logic          sub_w;
    logic          arith_w;

    always_comb begin
        y_w     = opnd_i;
        sub_w   = 1'b0;
        arith_w = 1'b0;
        unique case (op_i)
            OP_ADD:  begin y_w = opnd_i; arith_w = 1'b1; end
            OP_SUB:  begin y_w = opnd_i; arith_w = 1'b1; sub_w = 1'b1; end
            OP_APAC,
            OP_MAC:  begin y_w = prod_i; arith_w = 1'b1; end
            OP_SPAC: begin y_w = prod_i; arith_w = 1'b1; sub_w = 1'b1; end
            OP_ADDB: begin y_w = accb_i; arith_w = 1'b1; end
            OP_SUBB: begin y_w = accb_i; arith_w = 1'b1; sub_w = 1'b1; end
            default: ;
        endcase

        sum_w = sub_w ? (acc_i - y_w) : (acc_i + y_w);

        acc_o    = acc_i;
        acc_we_o = 1'b1;
        ovf_o    = 1'b0;
        ovf_we_o = 1'b1;
        unique case (op_i)
            OP_LAC:  acc_o = opnd_i;
            OP_PAC:  acc_o = prod_i;
            OP_AND:  acc_o = acc_i & opnd_i;
            OP_OR:   acc_o = acc_i | opnd_i;
            OP_XOR:  acc_o = acc_i ^ opnd_i;
            default: begin
                if (arith_w) begin
                    acc_o = sum_w;
                    if (sub_w)
                        ovf_o = (acc_i[AW-1] != y_w[AW-1]) && (sum_w[AW-1] != acc_i[AW-1]);
                    else
                        ovf_o = (acc_i[AW-1] == y_w[AW-1]) && (sum_w[AW-1] != acc_i[AW-1]);
                end else begin
                    acc_we_o = 1'b0;
                    ovf_we_o = 1'b0;
                end
            end
        endcase
    end
endmodule

// File: rtl/fxp_mac_core.sv
module fxp_mac_core
    import mac_pkg::*;
#(
    parameter int DW     = 16,
    parameter int MAX_SH = 16,
    parameter int OSW    = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [3:0]     op_i,
    input  logic           src_imm_i,
    input  logic [DW-1:0]  bus_i,
    input  logic [DW-1:0]  imm_i,
    input  logic [4:0]     ish_i,
    input  logic [1:0]     pmode_i,
    input  logic [OSW-1:0] osh_i,
    input  logic           ohi_i,
    output logic [2*DW-1:0] acc_o,
    output logic [2*DW-1:0] accb_o,
    output logic [DW-1:0]   treg_o,
    output logic [2*DW-1:0] preg_o,
    output logic [DW-1:0]   store_o,
    output logic            ovf_o
);
    localparam int AW = 2 * DW;

    typedef struct packed {
        logic [AW-1:0] acc;
        logic [AW-1:0] accb;
        logic [DW-1:0] t;
        logic [AW-1:0] p;
        logic          ovf;
    } core_st_t;

    core_st_t st_d, st_q;

    mac_op_e       op_w;
    logic [DW-1:0] opnd_w;
    logic [AW-1:0] scaled_w;
    logic [AW-1:0] pshift_w;
    logic [AW-1:0] prod_w;
    logic [AW-1:0] alu_acc_w;
    logic          alu_we_w;
    logic          alu_ovf_w;
    logic          alu_ovf_we_w;

    assign op_w   = mac_op_e'(op_i);
    assign opnd_w = src_imm_i ? imm_i : bus_i;

    mac_in_scaler #(.DW(DW), .AW(AW), .MAX_SH(MAX_SH), .SHW(5)) u_in (
        .data_i (opnd_w),
        .sh_i   (ish_i),
        .data_o (scaled_w)
    );

    mac_prod_scaler #(.AW(AW)) u_prod (
        .prod_i (st_q.p),
        .mode_i (pmode_i),
        .prod_o (pshift_w)
    );

    mac_alu #(.AW(AW)) u_alu (
        .op_i     (op_w),
        .acc_i    (st_q.acc),
        .opnd_i   (scaled_w),
        .prod_i   (pshift_w),
        .accb_i   (st_q.accb),
        .acc_o    (alu_acc_w),
        .acc_we_o (alu_we_w),
        .ovf_o    (alu_ovf_w),
        .ovf_we_o (alu_ovf_we_w)
    );

    mac_out_shifter #(.DW(DW), .AW(AW), .OSW(OSW)) u_out (
        .acc_i   (st_q.acc),
        .sh_i    (osh_i),
        .hi_i    (ohi_i),
        .store_o (store_o)
    );

    always_comb begin
        prod_w = $signed({{DW{st_q.t[DW-1]}}, st_q.t}) *
                 $signed({{DW{opnd_w[DW-1]}}, opnd_w});
        st_d = st_q;
        if (alu_we_w)     st_d.acc = alu_acc_w;
        if (alu_ovf_we_w) st_d.ovf = alu_ovf_w;
        unique case (op_w)
            OP_LDT:        st_d.t    = opnd_w;
            OP_MPY,
            OP_MAC:        st_d.p    = prod_w;
            OP_SACB:       st_d.accb = st_q.acc;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign acc_o  = st_q.acc;
    assign accb_o = st_q.accb;
    assign treg_o = st_q.t;
    assign preg_o = st_q.p;
    assign ovf_o  = st_q.ovf;

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (acc_o == '0 && accb_o == '0 && treg_o == '0 && preg_o == '0 && !ovf_o));

    p_load_t_r2: assert property (@(posedge clk) disable iff (!rst_n)
        op_i == 4'd1 |=> treg_o == $past(src_imm_i ? imm_i : bus_i));

    p_mpy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        op_i == 4'd2 |=> preg_o == AW'($signed($past(treg_o)) * $signed($past(opnd_w))));

    p_accb_copy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        op_i == 4'd13 |=> accb_o == $past(acc_o));

    p_mac_old_prod_r9: assert property (@(posedge clk) disable iff (!rst_n)
        op_i == 4'd3 |=> acc_o == $past(acc_o) + $past(pshift_w));

    p_nop_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        op_i == 4'd0 |=> ($stable(acc_o) && $stable(accb_o) && $stable(treg_o)
                          && $stable(preg_o) && $stable(ovf_o)));
endmodule

// File: tb/sim_fxp_mac_core.sv
module sim_fxp_mac_core;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 18;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op = 4'd0;
    logic        src_imm = 1'b0;
    logic [15:0] bus = 16'd0;
    logic [15:0] imm = 16'd0;
    logic [4:0]  ish = 5'd0;
    logic [1:0]  pmode = 2'd0;
    logic [2:0]  osh = 3'd0;
    logic        ohi = 1'b0;
    logic [31:0] acc, accb, preg;
    logic [15:0] treg, store;
    logic        ovf;

    int n_run = 0;
    int n_fail = 0;

    fxp_mac_core u0 (
        .clk(clk), .rst_n(rst_n), .op_i(op), .src_imm_i(src_imm),
        .bus_i(bus), .imm_i(imm), .ish_i(ish), .pmode_i(pmode),
        .osh_i(osh), .ohi_i(ohi), .acc_o(acc), .accb_o(accb),
        .treg_o(treg), .preg_o(preg), .store_o(store), .ovf_o(ovf)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // {op, bus data, ish, pmode, expected acc, expected product}
    localparam logic [90:0] VEC [NVEC] = '{
        {4'd1,  16'h0003, 5'd0,  2'd0, 32'h00000000, 32'h00000000},
        {4'd2,  16'hFFFE, 5'd0,  2'd0, 32'h00000000, 32'hFFFFFFFA},
        {4'd9,  16'h0000, 5'd0,  2'd0, 32'hFFFFFFFA, 32'hFFFFFFFA},
        {4'd7,  16'h0000, 5'd0,  2'd1, 32'hFFFFFFEE, 32'hFFFFFFFA},
        {4'd4,  16'h0001, 5'd16, 2'd0, 32'h00010000, 32'hFFFFFFFA},
        {4'd7,  16'h0000, 5'd0,  2'd2, 32'h0000FFA0, 32'hFFFFFFFA},
        {4'd4,  16'h8000, 5'd0,  2'd0, 32'hFFFF8000, 32'hFFFFFFFA},
        {4'd5,  16'h0100, 5'd4,  2'd0, 32'hFFFF9000, 32'hFFFFFFFA},
        {4'd6,  16'h0001, 5'd0,  2'd0, 32'hFFFF8FFF, 32'hFFFFFFFA},
        {4'd10, 16'h00F0, 5'd8,  2'd0, 32'h00008000, 32'hFFFFFFFA},
        {4'd11, 16'h0012, 5'd0,  2'd0, 32'h00008012, 32'hFFFFFFFA},
        {4'd12, 16'hFFFF, 5'd0,  2'd0, 32'hFFFF7FED, 32'hFFFFFFFA},
        {4'd1,  16'h7FFF, 5'd0,  2'd0, 32'hFFFF7FED, 32'hFFFFFFFA},
        {4'd2,  16'h7FFF, 5'd0,  2'd0, 32'hFFFF7FED, 32'h3FFF0001},
        {4'd9,  16'h0000, 5'd0,  2'd3, 32'h00FFFC00, 32'h3FFF0001},
        {4'd3,  16'h0002, 5'd0,  2'd0, 32'h40FEFC01, 32'h0000FFFE},
        {4'd3,  16'hFFFF, 5'd0,  2'd3, 32'h40FF0000, 32'hFFFF8001},
        {4'd9,  16'h0000, 5'd0,  2'd3, 32'hFFFFFE00, 32'hFFFF8001}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input logic [3:0] o, input logic s, input logic [15:0] b,
                        input logic [15:0] im, input logic [4:0] sh, input logic [1:0] pm);
        @(negedge clk);
        op = o; src_imm = s; bus = b; imm = im; ish = sh; pmode = pm;
        @(negedge clk);
        op = 4'd0;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 acc", acc, 32'h0);
        chk("R1 accb", accb, 32'h0);
        chk("R1 treg", {16'h0, treg}, 32'h0);
        chk("R1 preg", preg, 32'h0);
        chk("R1 ovf", {31'h0, ovf}, 32'h0);

        // Vector walk: R3 R4 R5 R6 R7 R9
        for (int i = 0; i < NVEC; i++) begin
            step(VEC[i][90:87], 1'b0, VEC[i][86:71], 16'h0, VEC[i][70:66], VEC[i][65:64]);
            chk($sformatf("R4/R5/R7/R9 vec%0d acc", i), acc, VEC[i][63:32]);
            chk($sformatf("R3/R9 vec%0d preg", i), preg, VEC[i][31:0]);
        end

        // R2 immediate versus bus source
        step(4'd1, 1'b1, 16'h0009, 16'h0005, 5'd0, 2'd0);
        chk("R2 treg from imm", {16'h0, treg}, 32'h5);
        step(4'd2, 1'b1, 16'h0009, 16'h0004, 5'd0, 2'd0);
        chk("R3 product imm", preg, 32'd20);
        step(4'd1, 1'b0, 16'hFFF0, 16'h0005, 5'd0, 2'd0);
        chk("R2 treg from bus", {16'h0, treg}, 32'h0000FFF0);

        // R5 shift clamp
        step(4'd4, 1'b0, 16'h0001, 16'h0, 5'd31, 2'd0);
        chk("R5 clamp", acc, 32'h00010000);

        // R6 overflow on add, then cleared by load
        step(4'd4, 1'b0, 16'h7FFF, 16'h0, 5'd16, 2'd0);
        step(4'd5, 1'b0, 16'h7FFF, 16'h0, 5'd16, 2'd0);
        chk("R6 add wrap", acc, 32'hFFFE0000);
        chk("R6 add ovf", {31'h0, ovf}, 32'h1);
        // R11 NOP holds everything
        step(4'd0, 1'b1, 16'hAAAA, 16'h5555, 5'd3, 2'd1);
        chk("R11 nop acc", acc, 32'hFFFE0000);
        chk("R11 nop ovf", {31'h0, ovf}, 32'h1);
        chk("R11 nop treg", {16'h0, treg}, 32'h0000FFF0);
        chk("R11 nop preg", preg, 32'd20);
        chk("R11 nop accb", accb, 32'h0);
        step(4'd4, 1'b0, 16'h0000, 16'h0, 5'd0, 2'd0);
        chk("R6 ovf cleared", {31'h0, ovf}, 32'h0);

        // R6 overflow on subtract
        step(4'd4, 1'b0, 16'h8000, 16'h0, 5'd16, 2'd0);
        step(4'd6, 1'b0, 16'h0001, 16'h0, 5'd0, 2'd0);
        chk("R6 sub wrap", acc, 32'h7FFFFFFF);
        chk("R6 sub ovf", {31'h0, ovf}, 32'h1);

        // R8 buffer copy and use
        step(4'd13, 1'b0, 16'h0, 16'h0, 5'd0, 2'd0);
        chk("R8 accb copy", accb, 32'h7FFFFFFF);
        chk("R8 ovf held", {31'h0, ovf}, 32'h1);
        step(4'd4, 1'b0, 16'h0001, 16'h0, 5'd0, 2'd0);
        step(4'd14, 1'b0, 16'h0, 16'h0, 5'd0, 2'd0);
        chk("R8 addb", acc, 32'h80000000);
        chk("R8 addb ovf", {31'h0, ovf}, 32'h1);
        step(4'd15, 1'b0, 16'h0, 16'h0, 5'd0, 2'd0);
        chk("R8 subb", acc, 32'h00000001);
        chk("R8 subb ovf", {31'h0, ovf}, 32'h1);

        // R10 store shifter
        step(4'd4, 1'b0, 16'h1234, 16'h0, 5'd16, 2'd0);
        step(4'd5, 1'b0, 16'h2BCD, 16'h0, 5'd0, 2'd0);
        step(4'd11, 1'b0, 16'h8000, 16'h0, 5'd0, 2'd0);
        chk("R10 setup acc", acc, 32'hFFFFABCD);
        step(4'd10, 1'b0, 16'h1234, 16'h0, 5'd16, 2'd0);
        step(4'd11, 1'b0, 16'h2BCD, 16'h0, 5'd0, 2'd0);
        step(4'd11, 1'b0, 16'h0800, 16'h0, 5'd4, 2'd0);
        chk("R10 acc", acc, 32'h1234ABCD);
        osh = 3'd0; ohi = 1'b1; #1;
        chk("R10 hi sh0", {16'h0, store}, 32'h1234);
        ohi = 1'b0; #1;
        chk("R10 lo sh0", {16'h0, store}, 32'hABCD);
        osh = 3'd4; ohi = 1'b1; #1;
        chk("R10 hi sh4", {16'h0, store}, 32'h234A);
        ohi = 1'b0; #1;
        chk("R10 lo sh4", {16'h0, store}, 32'hBCD0);
        osh = 3'd7; ohi = 1'b1; #1;
        chk("R10 hi sh7", {16'h0, store}, 32'h1A55);
        ohi = 1'b0; #1;
        chk("R10 lo sh7", {16'h0, store}, 32'hE680);

        // R1 reset mid-run
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1 reset acc", acc, 32'h0);
        chk("R1 reset preg", preg, 32'h0);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule